// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This block collects up to 32 external request lines, keeps an enable bit, a pending bit and a small priority code for each line, and presents the most urgent serviceable line to a processor as a vector number. Software reaches the state through a flat register window. Enable and pending each have two views, one that sets bits and one that clears them. A write changes only the bits written as one, so two software agents can change different lines without a read-modify-write race.

Hardware requests enter on `irq_req`. A build parameter chooses how they are captured: as a rising edge, which is the default, or as a level. Requests pass through one register before capture. The winner is the enabled, pending line with the numerically smallest priority code, and on a tie the lower line number wins. The winner is shown as line number plus 16, and 0 means that no line can be serviced. When the processor takes the interrupt it pulses `irq_ack`, and the pending bit of the line shown at that moment is cleared.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every enable bit, pending bit and priority code is zero, `win_vec` is 0 and `any_pend` is 0.
- R2: A write to offset 0x100 enables each line whose data bit is 1 and leaves the other lines unchanged. Reads of 0x100 and of 0x180 both return the enable bits, with line n in bit n.
- R3: A write to offset 0x180 disables each line whose data bit is 1. Data bits that are 0 leave their lines unchanged.
- R4: A write to offset 0x200 sets the pending bit of each line whose data bit is 1, and a write to 0x280 clears it. Zero bits have no effect in both cases. Reads of either offset return the pending bits.
- R5: Priority word k sits at offset 0x400+4k. Line 4k+j holds its 2-bit code in bits [8j+7:8j+6] of that word. All other bits of the priority words read as zero.
- R6: `win_vec` equals n+16, where n is the enabled pending line with the smallest priority code (code 0 is the most urgent). On equal codes the lower n wins. When no line is both enabled and pending, `win_vec` is 0. A read of offset 0xD04 returns `win_vec` in bits [20:12].
- R7: In edge mode, a 0-to-1 change on `irq_req[n]` sets pending n two clock edges after the change. A request that stays high does not set pending again after pending has been cleared.
- R8: When `irq_ack` is high at a clock edge, the pending bit of the line shown on `win_vec` is cleared. When `win_vec` is 0, `irq_ack` has no effect.
- R9: When a hardware set and a clear (from a write to 0x280 or from an acknowledge) reach the same line in the same cycle, the set wins.
- R10: `any_pend` is 1 whenever any pending bit is set, whether or not that line is enabled. Bit 22 of the word read at 0xD04 mirrors it.
- R11: A read of any offset not named above returns zero, and a write to such an offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 32 | Hardware request lines |
| irq_ack | input | 1 | Acknowledge; clears the pending bit of the line shown as winner |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset, used for both reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| win_vec | output | 9 | Vector of the winning line, or 0 |
| any_pend | output | 1 | High when any pending bit is set |

## Verification
The in-RTL properties check four things on every cycle. A shown winner is always enabled and pending. A set-enable or set-pending write leaves every written-one bit set. A clear-enable write leaves every written-one bit cleared. An acknowledge removes the winner's pending bit unless a set collides with it. They also check that `any_pend` can fall only after an acknowledge or a clear-pending write. These properties cannot show that the winner is the most urgent line, that ties go to the lower number, where the priority fields sit, or how edge capture times its response. Only the bench can show those, by comparing against its behavioural model on every cycle while it runs directed scenarios and a random burst.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int ADDR_W        = 12;
   localparam int DATA_W        = 32;
   localparam int VEC_W         = 9;
   localparam int VEC_BASE      = 16;
   localparam int STAT_VEC_LSB  = 12;
   localparam int STAT_ANY_BIT  = 22;

   localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h100;
   localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h180;
   localparam logic [ADDR_W-1:0] OFS_PD_SET   = 12'h200;
   localparam logic [ADDR_W-1:0] OFS_PD_CLR   = 12'h280;
   localparam logic [ADDR_W-1:0] OFS_PRI_BASE = 12'h400;
   localparam logic [ADDR_W-1:0] OFS_STATUS   = 12'hD04;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
   parameter int N        = 32,
   parameter bit LEVEL_IN = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] set_o
);
   logic [N-1:0] req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_i;
   end

   if (LEVEL_IN) begin : g_level
      assign set_o = req_q;
   end else begin : g_edge
      logic [N-1:0] req_qq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_qq <= '0;
         else        req_qq <= req_q;
      end
      assign set_o = req_q & ~req_qq;
   end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
   parameter int N  = 32,
   parameter int PW = 2,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  elig_i,
   input  logic [PW-1:0] pri_i [N],
   output logic          valid_o,
   output logic [IW-1:0] idx_o
);
   logic [PW-1:0] best;

   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      best    = '1;
      for (int i = 0; i < N; i++) begin
         // strict compare on ascending scan: ties stay with the lower line
         if (elig_i[i] && (!valid_o || (pri_i[i] < best))) begin
            valid_o = 1'b1;
            idx_o   = IW'(i);
            best    = pri_i[i];
         end
      end
   end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int N  = 32,
   parameter int PW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [N-1:0]      hw_set_i,
   input  logic [N-1:0]      ack_clr_i,
   input  logic [VEC_W-1:0]  win_vec_i,
   input  logic              any_pend_i,
   output logic [N-1:0]      en_o,
   output logic [N-1:0]      pend_o,
   output logic [PW-1:0]     pri_o [N],
   output logic [DATA_W-1:0] rdata_o
);
   logic [N-1:0] en_q, pend_q;
   logic [N-1:0] wmask;
   logic         w_en_set, w_en_clr, w_pd_set, w_pd_clr, pri_hit;
   logic [2:0]   wsel;

   assign wmask    = wdata_i[N-1:0];
   assign w_en_set = wr_i && (addr_i == OFS_EN_SET);
   assign w_en_clr = wr_i && (addr_i == OFS_EN_CLR);
   assign w_pd_set = wr_i && (addr_i == OFS_PD_SET);
   assign w_pd_clr = wr_i && (addr_i == OFS_PD_CLR);
   assign pri_hit  = (addr_i[ADDR_W-1:5] == OFS_PRI_BASE[ADDR_W-1:5]) && (addr_i[1:0] == 2'b00);
   assign wsel     = addr_i[4:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else begin
         en_q <= (en_q | (w_en_set ? wmask : '0)) & ~(w_en_clr ? wmask : '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         // sets are applied after clears, so a colliding set survives
         pend_q <= (pend_q & ~((w_pd_clr ? wmask : '0) | ack_clr_i))
                   | (w_pd_set ? wmask : '0) | hw_set_i;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_pri
      localparam int WRD = i / 4;
      localparam int LN  = i % 4;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    pri_o[i] <= '0;
         else if (wr_i && pri_hit && (wsel == 3'(WRD))) pri_o[i] <= wdata_i[8*LN+7 -: PW];
      end
   end

   always_comb begin
      rdata_o = '0;
      if ((addr_i == OFS_EN_SET) || (addr_i == OFS_EN_CLR)) begin
         rdata_o[N-1:0] = en_q;
      end else if ((addr_i == OFS_PD_SET) || (addr_i == OFS_PD_CLR)) begin
         rdata_o[N-1:0] = pend_q;
      end else if (pri_hit) begin
         for (int i = 0; i < N; i++) begin
            if ((i / 4) == int'(wsel)) rdata_o[8*(i%4)+7 -: PW] = pri_o[i];
         end
      end else if (addr_i == OFS_STATUS) begin
         rdata_o[STAT_VEC_LSB +: VEC_W] = win_vec_i;
         rdata_o[STAT_ANY_BIT]          = any_pend_i;
      end
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;

   // R2
   seten_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_en_set |=> ((en_q & $past(wmask)) == $past(wmask)));
   // R3
   clren_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_en_clr |=> ((en_q & $past(wmask)) == '0));
   // R4
   setpd_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_pd_set |=> ((pend_q & $past(wmask)) == $past(wmask)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_IRQ  = 32,
   parameter int PRI_BITS = 2,
   parameter bit LEVEL_IN = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_IRQ-1:0]    irq_req,
   input  logic                  irq_ack,
   input  logic                  bus_wr,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic [VEC_W-1:0]      win_vec,
   output logic                  any_pend
);
   localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   if ((NUM_IRQ < 1) || (NUM_IRQ > 32)) begin : g_bad_num
      $error("NUM_IRQ must lie in 1..32");
   end
   if ((PRI_BITS < 1) || (PRI_BITS > 8)) begin : g_bad_pri
      $error("PRI_BITS must lie in 1..8");
   end

   logic [NUM_IRQ-1:0]  hw_set, en, pend, ack_clr;
   logic [PRI_BITS-1:0] pri [NUM_IRQ];
   logic                win_valid;
   logic [IW-1:0]       win_idx;

   irqc_capture #(.N(NUM_IRQ), .LEVEL_IN(LEVEL_IN)) cap_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (irq_req),
      .set_o (hw_set)
   );

   irqc_arbiter #(.N(NUM_IRQ), .PW(PRI_BITS)) arb_i (
      .elig_i  (en & pend),
      .pri_i   (pri),
      .valid_o (win_valid),
      .idx_o   (win_idx)
   );

   assign ack_clr  = (irq_ack && win_valid) ? (NUM_IRQ'(1) << win_idx) : '0;
   assign win_vec  = win_valid ? (VEC_W'(win_idx) + VEC_W'(VEC_BASE)) : '0;
   assign any_pend = |pend;

   irqc_regs #(.N(NUM_IRQ), .PW(PRI_BITS)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr),
      .addr_i     (bus_addr),
      .wdata_i    (bus_wdata),
      .hw_set_i   (hw_set),
      .ack_clr_i  (ack_clr),
      .win_vec_i  (win_vec),
      .any_pend_i (any_pend),
      .en_o       (en),
      .pend_o     (pend),
      .pri_o      (pri),
      .rdata_o    (bus_rdata)
   );

   // R6
   win_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (en[win_idx] && pend[win_idx]));
   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && win_valid && !hw_set[win_idx]
       && !(bus_wr && (bus_addr == OFS_PD_SET) && bus_wdata[win_idx]))
      |=> !pend[$past(win_idx)]);
   // R10
   any_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(any_pend) |-> $past(irq_ack || (bus_wr && (bus_addr == OFS_PD_CLR))));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_req = '0;
   logic        irq_ack = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [8:0]  win_vec;
   logic        any_pend;

   int checks = 0;
   int errors = 0;

   // behavioural model state
   logic [31:0] m_en = '0, m_pend = '0, m_rq = '0, m_rqq = '0;
   int          m_pri [32];

   always #2 clk = ~clk;

   irq_prio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .win_vec(win_vec), .any_pend(any_pend)
   );

   function automatic int m_winner();
      int w = -1;
      int b = 99;
      for (int i = 0; i < 32; i++)
         if (m_en[i] && m_pend[i] && m_pri[i] < b) begin w = i; b = m_pri[i]; end
      return w;
   endfunction

   function automatic logic [31:0] m_read(input logic [11:0] a);
      logic [31:0] r = '0;
      int w = m_winner();
      if (a == 12'h100 || a == 12'h180) r = m_en;
      else if (a == 12'h200 || a == 12'h280) r = m_pend;
      else if (a >= 12'h400 && a <= 12'h41C && a[1:0] == 2'b00) begin
         int k = (int'(a) - 'h400) / 4;
         for (int j = 0; j < 4; j++) r[8*j+6 +: 2] = 2'(m_pri[4*k+j]);
      end else if (a == 12'hD04) begin
         r[20:12] = (w < 0) ? 9'd0 : 9'(w + 16);
         r[22]    = |m_pend;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic wr, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] req, input logic ack, input string tag);
      int w;
      logic [31:0] setm, clrm;
      @(negedge clk);
      bus_wr = wr; bus_addr = a; bus_wdata = d; irq_req = req; irq_ack = ack;
      #1;
      w = m_winner();
      check("R6 win_vec", 32'(win_vec), (w < 0) ? 32'd0 : 32'(w + 16));
      check("R10 any_pend", 32'(any_pend), 32'(|m_pend));
      check({tag, " rdata"}, bus_rdata, m_read(a));
      @(posedge clk);
      setm = m_rq & ~m_rqq;
      clrm = '0;
      m_rqq = m_rq;
      m_rq = req;
      if (wr) begin
         if (a == 12'h100) m_en = m_en | d;
         else if (a == 12'h180) m_en = m_en & ~d;
         else if (a == 12'h200) setm = setm | d;
         else if (a == 12'h280) clrm = d;
         else if (a >= 12'h400 && a <= 12'h41C && a[1:0] == 2'b00) begin
            int k = (int'(a) - 'h400) / 4;
            for (int j = 0; j < 4; j++) m_pri[4*k+j] = int'(d[8*j+6 +: 2]);
         end
      end
      if (ack && w >= 0) clrm[w] = 1'b1;
      m_pend = (m_pend & ~clrm) | setm;
   endtask

   task automatic rd(input logic [11:0] a, input string tag);
      cyc(1'b0, a, '0, irq_req, 1'b0, tag);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
      cyc(1'b1, a, d, irq_req, 1'b0, tag);
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) m_pri[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      rd(12'h100, "R1"); rd(12'h200, "R1"); rd(12'h41C, "R1"); rd(12'hD04, "R1");
      // R2 set-enable, zero bits inert
      wr(12'h100, 32'h0000_00F0, "R2"); wr(12'h100, 32'h0, "R2");
      rd(12'h100, "R2"); rd(12'h180, "R2");
      // R3 clear-enable
      wr(12'h180, 32'h0000_0010, "R3"); wr(12'h180, 32'h0, "R3"); rd(12'h100, "R3");
      // R4 and R10: pending on disabled lines
      wr(12'h200, 32'h0000_0300, "R4"); rd(12'h280, "R4"); rd(12'hD04, "R10");
      wr(12'h280, 32'h0000_0100, "R4"); wr(12'h280, 32'h0, "R4"); rd(12'h200, "R4");
      // R5 priority fields
      wr(12'h400, 32'hFFFF_FFFF, "R5"); rd(12'h400, "R5");
      wr(12'h404, 32'h40_80_C0_00, "R5"); rd(12'h404, "R5");
      wr(12'h408, 32'h3F3F_3F3F, "R5"); rd(12'h408, "R5");
      // R6 winner selection, R8 acknowledge
      wr(12'h200, 32'h0000_00F0, "R6"); rd(12'hD04, "R6");
      cyc(1'b0, 12'hD04, '0, '0, 1'b1, "R8"); rd(12'hD04, "R8");
      wr(12'h100, 32'h0000_0010, "R6"); rd(12'hD04, "R6");
      wr(12'h404, 32'h0, "R6"); rd(12'hD04, "R6");            // tie on code 0
      wr(12'h100, 32'h0000_0300, "R6"); wr(12'h200, 32'h0000_0100, "R6");
      wr(12'h280, 32'h0000_00F0, "R6"); rd(12'hD04, "R6");     // tie 8 vs 9
      // R7 edge capture
      wr(12'h100, 32'h0010_0000, "R7");
      cyc(1'b0, 12'h200, '0, 32'h0010_0000, 1'b0, "R7");
      cyc(1'b0, 12'h200, '0, 32'h0010_0000, 1'b0, "R7");
      rd(12'h200, "R7");
      wr(12'h280, 32'h0010_0000, "R7");
      repeat (3) rd(12'h200, "R7");
      cyc(1'b0, 12'h200, '0, 32'h0, 1'b0, "R7");
      cyc(1'b0, 12'h200, '0, 32'h0010_0000, 1'b0, "R7");
      repeat (2) rd(12'h200, "R7");
      // R9 hardware set colliding with clear
      cyc(1'b0, 12'h200, '0, 32'h0030_0000, 1'b0, "R9");
      cyc(1'b1, 12'h280, 32'h0020_0000, 32'h0030_0000, 1'b0, "R9");
      rd(12'h200, "R9");
      // R8 acknowledge with nothing eligible
      wr(12'h280, 32'hFFFF_FFFF, "R8"); wr(12'h200, 32'h8000_0000, "R8");
      wr(12'h180, 32'h8000_0000, "R8");
      cyc(1'b0, 12'h200, '0, irq_req, 1'b1, "R8"); rd(12'h200, "R8");
      // R11 unmapped offsets
      wr(12'h300, 32'hFFFF_FFFF, "R11"); rd(12'h300, "R11"); rd(12'hD00, "R11");
      wr(12'h402, 32'hFFFF_FFFF, "R11"); rd(12'h400, "R11"); rd(12'h100, "R11");
      // random burst, compared every cycle
      for (int n = 0; n < 400; n++) begin
         logic [11:0] addrs [9] = '{12'h100, 12'h180, 12'h200, 12'h280, 12'h400,
                                    12'h40C, 12'h41C, 12'hD04, 12'h300};
         cyc(1'($urandom_range(0, 1)), addrs[$urandom_range(0, 8)], $urandom(),
             $urandom() & $urandom(), 1'($urandom_range(0, 1)), "R6");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule